// File: doc/BRIEF.md
# SDRAM Write and Mode-Load Command Sequencer

This block turns two kinds of request into SDRAM pin activity: loading the mode register, and writing a burst to one bank. The write leaves the bank closed again by automatic precharge. Requests arrive on a valid/ready port. The block accepts one request at a time whenever it is idle. For a write it activates the target row, waits out the row-to-column delay with NOP cycles, and issues the write. It streams one data word per clock from a pop-style data input. It then holds the command bus at NOP for one combined window that covers the rest of the burst, write recovery and precharge.

Timing gaps and field widths are fixed at elaboration. The burst length comes from the last accepted mode load, and no write runs before the first one. A burst-length code of 7 selects a full-page burst. Such a write leaves auto-precharge off and the bank stays open. A per-bank open flag is kept. A mode load, or a write to a bank that is still open, is preceded by a precharge of all banks and its tRP wait.

Top module: `sdram_wrseq`

## Requirements
- R1: An accepted write to an idle bank places ACTIVATE on the pins in the next cycle (CS#,RAS#,CAS#,WE# = 0,0,1,1, BA = bank, A = row), followed by T_RCD-1 NOP cycles (0,1,1,1), and then the WRITE command.
- R2: The WRITE command is encoded as CS#,RAS#,CAS#,WE# = 0,1,0,0, with BA = bank, the column on the low COL_W address bits, A10 high when auto-precharge is in effect, and all other address bits zero.
- R3: The mode-load command is encoded as 0,0,0,0 and carries the requested 12-bit value on A, with A10 forced low.
- R4: A mode load is issued only when no bank is open. If any bank is open, a precharge-all (0,0,1,0 with A10 high and the rest of A zero) goes out first and is followed by T_RP NOP cycles.
- R5: After a mode load, T_MRD NOP cycles follow before the block is ready again.
- R6: A write request accepted before any mode load is dropped, and no command appears on the pins.
- R7: After an auto-precharge WRITE, exactly (BL-1)+T_WR+T_RP NOP cycles follow, and the block is ready in the next cycle.
- R8: When the burst-length code is 7, the burst is 2^COL_W words, A10 is low on the WRITE, and the lockout is (BL-1)+T_WR. The bank stays open, and a later write to it is preceded by precharge-all and T_RP NOP cycles. ACTIVATE never targets an open bank.
- R9: Write data word k appears on DQ in the cycle k after WRITE, with DQM all low and wd_pop high. In every other cycle DQM is all high, wd_pop is low and DQ is released.
- R10: Mode value bits [2:0] select the burst length: 0→1, 1→2, 2→4, 3→8, 7→full page. Codes 4, 5 and 6 are rejected. The request is consumed, no command appears, and the previous burst length stays in force.
- R11: In and right after reset the block is ready, the pins show NOP, DQM is all high and wd_pop is low.
- R12: req_ready is high only while the block is idle, and the command bus then shows NOP. A request is taken in a cycle where req_valid and req_ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and taking a request |
| req_is_mode | input | 1 | 1 = mode load, 0 = write |
| req_bank | input | BA_W | Target bank of a write |
| req_row | input | ROW_W | Row address of a write |
| req_col | input | COL_W | Start column of a write |
| req_mode_val | input | ADDR_W | Value for the mode register |
| wd_in | input | DQ_W | Current write data word |
| wd_pop | output | 1 | Current word consumed this cycle |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_a | output | ADDR_W | Address bus |
| sd_dq | inout | DQ_W | Data bus, driven only during write beats |
| sd_dqm | output | DQM_W | Byte masks, low during write beats |

## Verification
The bound checker rebuilds the open-bank state, the loaded burst length and every NOP window from the pins alone. It then checks on every cycle that the row-to-column, precharge, mode-load and post-write lockout windows carry only NOP. It also checks that no mode load or ACTIVATE meets an open bank, that A10 matches the auto-precharge choice, and that DQM is low exactly on the data beats. Some behaviour only the bench scenarios can show: the exact row, column and data values, the dropping of early writes and reserved codes with the old burst length kept in force, the precharge-all inserted before reuse of a full-page bank, and the exact cycle in which ready returns.

// File: rtl/sdram_wrseq_pkg.sv
package sdram_wrseq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_WR,
    CMD_PRE,
    CMD_MRS
  } sd_cmd_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PRE,
    S_PREW,
    S_ACT,
    S_RCD,
    S_WR,
    S_BURST,
    S_LOCK,
    S_MRS,
    S_MRD
  } seq_st_e;

  localparam logic [2:0] BL_CODE_FULL = 3'd7;

  function automatic logic bl_is_reserved(input logic [2:0] code);
    return (code == 3'd4) || (code == 3'd5) || (code == 3'd6);
  endfunction

  function automatic logic bl_is_full(input logic [2:0] code);
    return code == BL_CODE_FULL;
  endfunction

endpackage

// File: rtl/sdram_wrseq_timer.sv
module sdram_wrseq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ld) begin
      cnt_d = ld_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdram_wrseq_banks.sv
module sdram_wrseq_banks #(
  parameter int BA_W = 2,
  localparam int BANKS = 1 << BA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act_en,
  input  logic [BA_W-1:0] act_bank,
  input  logic            pre_all,
  input  logic            close_en,
  input  logic [BA_W-1:0] close_bank,
  output logic [BANKS-1:0] open_mask
);

  for (genvar gb = 0; gb < BANKS; gb++) begin : g_bank
    logic open_q;
    logic open_d;
    logic hit_act;
    logic hit_close;

    assign hit_act   = act_en && (act_bank == BA_W'(gb));
    assign hit_close = pre_all || (close_en && (close_bank == BA_W'(gb)));

    always_comb begin
      open_d = open_q;
      if (hit_close) begin
        open_d = 1'b0;
      end else if (hit_act) begin
        open_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q <= 1'b0;
      end else begin
        open_q <= open_d;
      end
    end

    assign open_mask[gb] = open_q;
  end

endmodule

// File: rtl/sdram_wrseq_pins.sv
module sdram_wrseq_pins
  import sdram_wrseq_pkg::*;
#(
  parameter int DQ_W  = 16,
  parameter int DQM_W = DQ_W / 8
) (
  input  sd_cmd_e          cmd,
  input  logic             dq_oe,
  input  logic [DQ_W-1:0]  wd_in,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [DQM_W-1:0] dqm,
  inout  wire  [DQ_W-1:0]  dq
);

  logic [3:0] enc;

  always_comb begin
    case (cmd)
      CMD_ACT: enc = 4'b0011;
      CMD_WR:  enc = 4'b0100;
      CMD_PRE: enc = 4'b0010;
      CMD_MRS: enc = 4'b0000;
      default: enc = 4'b0111;
    endcase
  end

  assign cs_n  = enc[3];
  assign ras_n = enc[2];
  assign cas_n = enc[1];
  assign we_n  = enc[0];

  assign dqm = dq_oe ? '0 : '1;
  assign dq  = dq_oe ? wd_in : 'z;

endmodule

// File: rtl/sdram_wrseq.sv
module sdram_wrseq
  import sdram_wrseq_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 12,
  parameter int DQ_W   = 16,
  parameter int DQM_W  = DQ_W / 8,
  parameter int T_RCD  = 2,
  parameter int T_WR   = 2,
  parameter int T_RP   = 2,
  parameter int T_MRD  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_mode,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [ADDR_W-1:0] req_mode_val,
  input  logic [DQ_W-1:0]   wd_in,
  output logic              wd_pop,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_a,
  inout  wire  [DQ_W-1:0]   sd_dq,
  output logic [DQM_W-1:0]  sd_dqm
);

  localparam int BANKS    = 1 << BA_W;
  localparam int FP_BEATS = 1 << COL_W;
  localparam int CNT_W    = $clog2(FP_BEATS + T_WR + T_RP + T_RCD + T_MRD) + 1;
  localparam int AP_BIT   = 10;
  localparam int RCD_LD   = (T_RCD > 1) ? T_RCD - 2 : 0;

  // state and captured request
  seq_st_e           state_q, state_d;
  logic              op_mode_q;
  logic [BA_W-1:0]   bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [ADDR_W-1:0] mval_q;
  logic              loaded_q;
  logic [2:0]        bl_q;

  logic              accept;
  logic              mrs_fire;
  logic              fp;
  logic [CNT_W-1:0]  beats;
  logic [CNT_W-1:0]  lock_len;
  logic              t_ld;
  logic [CNT_W-1:0]  t_val;
  logic              t_zero;
  logic [BANKS-1:0]  open_mask;
  sd_cmd_e           cmd;
  logic              dq_oe;

  assign req_ready = (state_q == S_IDLE);
  assign accept    = req_ready && req_valid;
  assign mrs_fire  = (state_q == S_MRS);

  assign fp       = bl_is_full(bl_q);
  assign beats    = fp ? CNT_W'(FP_BEATS) : (CNT_W'(1) << bl_q[1:0]);
  assign lock_len = CNT_W'(T_WR) + (fp ? '0 : CNT_W'(T_RP));

  // next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          if (req_is_mode) begin
            if (bl_is_reserved(req_mode_val[2:0])) begin
              state_d = S_IDLE;
            end else if (|open_mask) begin
              state_d = S_PRE;
            end else begin
              state_d = S_MRS;
            end
          end else begin
            if (!loaded_q) begin
              state_d = S_IDLE;
            end else if (open_mask[req_bank]) begin
              state_d = S_PRE;
            end else begin
              state_d = S_ACT;
            end
          end
        end
      end
      S_PRE:   state_d = S_PREW;
      S_PREW:  if (t_zero) state_d = op_mode_q ? S_MRS : S_ACT;
      S_ACT:   state_d = (T_RCD > 1) ? S_RCD : S_WR;
      S_RCD:   if (t_zero) state_d = S_WR;
      S_WR:    state_d = (beats > CNT_W'(1)) ? S_BURST : S_LOCK;
      S_BURST: if (t_zero) state_d = S_LOCK;
      S_LOCK:  if (t_zero) state_d = S_IDLE;
      S_MRS:   state_d = S_MRD;
      S_MRD:   if (t_zero) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // wait-state timer load: stays N cycles when loaded with N-1
  always_comb begin
    t_ld  = 1'b0;
    t_val = '0;
    if (state_d != state_q) begin
      case (state_d)
        S_PREW:  begin t_ld = 1'b1; t_val = CNT_W'(T_RP - 1);  end
        S_RCD:   begin t_ld = 1'b1; t_val = CNT_W'(RCD_LD);    end
        S_BURST: begin t_ld = 1'b1; t_val = beats - CNT_W'(2); end
        S_LOCK:  begin t_ld = 1'b1; t_val = lock_len - 1'b1;   end
        S_MRD:   begin t_ld = 1'b1; t_val = CNT_W'(T_MRD - 1); end
        default: begin t_ld = 1'b0; t_val = '0;                end
      endcase
    end
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // request capture, enabled on accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_mode_q <= 1'b0;
      bank_q    <= '0;
      row_q     <= '0;
      col_q     <= '0;
      mval_q    <= '0;
    end else if (accept) begin
      op_mode_q <= req_is_mode;
      bank_q    <= req_bank;
      row_q     <= req_row;
      col_q     <= req_col;
      mval_q    <= req_mode_val;
    end
  end

  // mode state, enabled when the load goes out
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      bl_q     <= '0;
    end else if (mrs_fire) begin
      loaded_q <= 1'b1;
      bl_q     <= mval_q[2:0];
    end
  end

  sdram_wrseq_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (t_ld),
    .ld_val (t_val),
    .zero   (t_zero)
  );

  sdram_wrseq_banks #(
    .BA_W (BA_W)
  ) u_banks (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_en     (state_q == S_ACT),
    .act_bank   (bank_q),
    .pre_all    (state_q == S_PRE),
    .close_en   ((state_q == S_LOCK) && t_zero && !fp),
    .close_bank (bank_q),
    .open_mask  (open_mask)
  );

  // command and address selection
  always_comb begin
    cmd   = CMD_NOP;
    sd_ba = '0;
    sd_a  = '0;
    case (state_q)
      S_ACT: begin
        cmd   = CMD_ACT;
        sd_ba = bank_q;
        sd_a  = ADDR_W'(row_q);
      end
      S_WR: begin
        cmd          = CMD_WR;
        sd_ba        = bank_q;
        sd_a         = ADDR_W'(col_q);
        sd_a[AP_BIT] = !fp;
      end
      S_PRE: begin
        cmd          = CMD_PRE;
        sd_a[AP_BIT] = 1'b1;
      end
      S_MRS: begin
        cmd          = CMD_MRS;
        sd_a         = mval_q;
        sd_a[AP_BIT] = 1'b0;
      end
      default: begin
        cmd = CMD_NOP;
      end
    endcase
  end

  assign dq_oe  = (state_q == S_WR) || (state_q == S_BURST);
  assign wd_pop = dq_oe;

  sdram_wrseq_pins #(
    .DQ_W  (DQ_W),
    .DQM_W (DQM_W)
  ) u_pins (
    .cmd   (cmd),
    .dq_oe (dq_oe),
    .wd_in (wd_in),
    .cs_n  (sd_cs_n),
    .ras_n (sd_ras_n),
    .cas_n (sd_cas_n),
    .we_n  (sd_we_n),
    .dqm   (sd_dqm),
    .dq    (sd_dq)
  );

endmodule

// File: rtl/sdram_wrseq_chk.sv
module sdram_wrseq_chk #(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 12,
  parameter int COL_W  = 9,
  parameter int DQM_W  = 2,
  parameter int T_RCD  = 2,
  parameter int T_WR   = 2,
  parameter int T_RP   = 2,
  parameter int T_MRD  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [BA_W-1:0]   sd_ba,
  input logic [ADDR_W-1:0] sd_a,
  input logic [DQM_W-1:0]  sd_dqm
);

  localparam int BANKS    = 1 << BA_W;
  localparam int FP_BEATS = 1 << COL_W;
  localparam int CW       = $clog2(FP_BEATS + T_WR + T_RP + T_RCD + T_MRD) + 1;

  logic [3:0] pins;
  logic is_nop, is_act, is_wr, is_pre, is_mrs;
  assign pins   = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_nop = (pins == 4'b0111);
  assign is_act = (pins == 4'b0011);
  assign is_wr  = (pins == 4'b0100);
  assign is_pre = (pins == 4'b0010);
  assign is_mrs = (pins == 4'b0000);

  logic [BANKS-1:0] open_m;
  logic             loaded_m;
  logic [2:0]       bl_m;
  logic [CW-1:0]    rcd_cnt, rp_cnt, mrd_cnt, lock_cnt, beat_cnt;
  logic             fp_m;
  logic [CW-1:0]    beats_m;

  assign fp_m    = (bl_m == 3'd7);
  assign beats_m = fp_m ? CW'(FP_BEATS) : (CW'(1) << bl_m[1:0]);

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] v);
    return (v != '0) ? v - 1'b1 : '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_m   <= '0;
      loaded_m <= 1'b0;
      bl_m     <= '0;
      rcd_cnt  <= '0;
      rp_cnt   <= '0;
      mrd_cnt  <= '0;
      lock_cnt <= '0;
      beat_cnt <= '0;
    end else begin
      rcd_cnt  <= is_act ? CW'(T_RCD - 1) : dec(rcd_cnt);
      rp_cnt   <= is_pre ? CW'(T_RP) : dec(rp_cnt);
      mrd_cnt  <= is_mrs ? CW'(T_MRD) : dec(mrd_cnt);
      lock_cnt <= is_wr ? (beats_m - 1'b1 + CW'(T_WR) + (fp_m ? '0 : CW'(T_RP)))
                        : dec(lock_cnt);
      beat_cnt <= is_wr ? beats_m - 1'b1 : dec(beat_cnt);
      if (is_mrs) begin
        loaded_m <= 1'b1;
        bl_m     <= sd_a[2:0];
      end
      if (is_pre && sd_a[10]) begin
        open_m <= '0;
      end else if (is_act) begin
        open_m[sd_ba] <= 1'b1;
      end else if (is_wr && sd_a[10]) begin
        open_m[sd_ba] <= 1'b0;
      end
    end
  end

  assert_rcd_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rcd_cnt != '0) |-> is_nop);

  assert_ap_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && !fp_m) |-> sd_a[10]);

  assert_mrs_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (open_m == '0));

  assert_rp_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_cnt != '0) |-> is_nop);

  assert_mrd_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_cnt != '0) |-> is_nop);

  assert_wr_after_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |-> loaded_m);

  assert_lockout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_cnt != '0) |-> is_nop);

  assert_fullpage_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && fp_m) |-> !sd_a[10]);

  assert_act_idle_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> !open_m[sd_ba]);

  assert_dqm_beats_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((is_wr || (beat_cnt != '0)) == (sd_dqm == '0)));

  assert_bl_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> !(sd_a[2:0] inside {3'd4, 3'd5, 3'd6}));

  assert_ready_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (is_nop && (sd_dqm == '1)));

endmodule

bind sdram_wrseq sdram_wrseq_chk #(
  .BA_W   (BA_W),
  .ADDR_W (ADDR_W),
  .COL_W  (COL_W),
  .DQM_W  (DQM_W),
  .T_RCD  (T_RCD),
  .T_WR   (T_WR),
  .T_RP   (T_RP),
  .T_MRD  (T_MRD)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .sd_cs_n   (sd_cs_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .sd_ba     (sd_ba),
  .sd_a      (sd_a),
  .sd_dqm    (sd_dqm)
);

// File: tb/sdram_wrseq_test.sv
module sdram_wrseq_test;

  localparam int T_RCD = 2;
  localparam int T_WR  = 2;
  localparam int T_RP  = 2;
  localparam int T_MRD = 2;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_MRS = 4'b0000;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_is_mode;
  logic [1:0]  req_bank;
  logic [11:0] req_row;
  logic [8:0]  req_col;
  logic [11:0] req_mode_val;
  logic [15:0] wd_in;
  logic        wd_pop;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [11:0] sd_a;
  wire  [15:0] dq_bus;
  logic [1:0]  sd_dqm;

  sdram_wrseq #(
    .T_RCD (T_RCD),
    .T_WR  (T_WR),
    .T_RP  (T_RP),
    .T_MRD (T_MRD)
  ) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_is_mode  (req_is_mode),
    .req_bank     (req_bank),
    .req_row      (req_row),
    .req_col      (req_col),
    .req_mode_val (req_mode_val),
    .wd_in        (wd_in),
    .wd_pop       (wd_pop),
    .sd_cs_n      (sd_cs_n),
    .sd_ras_n     (sd_ras_n),
    .sd_cas_n     (sd_cas_n),
    .sd_we_n      (sd_we_n),
    .sd_ba        (sd_ba),
    .sd_a         (sd_a),
    .sd_dq        (dq_bus),
    .sd_dqm       (sd_dqm)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks;
  int errors;
  bit finished;

  // bench model of the block's visible state
  bit         m_loaded;
  logic [2:0] m_bl;
  logic [3:0] m_open;
  int         exp_idx;
  int         widx;

  function automatic logic [15:0] pat(input int i);
    return 16'(i * 40503) ^ 16'h5A5A;
  endfunction

  function automatic int beats_of(input logic [2:0] code);
    return (code == 3'd7) ? 512 : (1 << code);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) widx <= 0;
    else if (wd_pop) widx <= widx + 1;
  end
  always_comb wd_in = pat(widx);

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic exp_cmd(input logic [3:0] code, input string tag);
    logic [3:0] p;
    p = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    check(p == code, tag, "command pins", 32'(p), 32'(code));
  endtask

  task automatic exp_addr(input logic [1:0] ba, input logic [11:0] a, input string tag);
    check(sd_ba == ba && sd_a == a, tag, "bank/address", {18'd0, sd_ba, sd_a}, {18'd0, ba, a});
  endtask

  task automatic exp_beat(input string tag);
    check(sd_dqm == 2'b00 && wd_pop && dq_bus === pat(exp_idx), tag, "data beat",
          {14'd0, sd_dqm, dq_bus}, {16'd0, pat(exp_idx)});
    exp_idx++;
  endtask

  task automatic exp_idle_nop(input string tag);
    exp_cmd(C_NOP, tag);
    check(sd_dqm == 2'b11 && !wd_pop, tag, "dqm/pop outside beats", {30'd0, sd_dqm}, 32'h3);
  endtask

  task automatic issue(input bit is_mode, input logic [1:0] b, input logic [11:0] row,
                       input logic [8:0] col, input logic [11:0] mv);
    while (!req_ready) @(negedge clk);
    req_is_mode  = is_mode;
    req_bank     = b;
    req_row      = row;
    req_col      = col;
    req_mode_val = mv;
    req_valid    = 1'b1;
    @(negedge clk);
    req_valid    = 1'b0;
  endtask

  task automatic precharge_seq(input string tag);
    exp_cmd(C_PRE, tag);
    exp_addr(2'd0, 12'h400, tag);
    @(negedge clk);
    for (int i = 0; i < T_RP; i++) begin
      exp_idle_nop(tag);
      @(negedge clk);
    end
    m_open = '0;
  endtask

  task automatic do_write(input logic [1:0] b, input logic [11:0] row, input logic [8:0] col);
    bit fp;
    int n;
    issue(1'b0, b, row, col, 12'h000);
    if (!m_loaded) begin
      exp_idle_nop("R6");
      check(req_ready, "R6", "write before mode load dropped", 32'(req_ready), 1);
      return;
    end
    fp = (m_bl == 3'd7);
    n  = beats_of(m_bl);
    if (m_open[b]) precharge_seq("R8");
    // R12: first command in the cycle after acceptance
    exp_cmd(C_ACT, "R1");
    exp_addr(b, row, "R1");
    @(negedge clk);
    for (int i = 0; i < T_RCD - 1; i++) begin
      exp_idle_nop("R1");
      @(negedge clk);
    end
    exp_cmd(C_WR, "R2");
    exp_addr(b, {2'b00, ~fp, 1'b0, col}, fp ? "R8" : "R2");
    exp_beat("R9");
    @(negedge clk);
    for (int k = 1; k < n; k++) begin
      exp_cmd(C_NOP, "R7");
      exp_beat("R9");
      @(negedge clk);
    end
    for (int i = 0; i < T_WR + (fp ? 0 : T_RP); i++) begin
      exp_idle_nop(fp ? "R8" : "R7");
      @(negedge clk);
    end
    check(req_ready, fp ? "R8" : "R7", "ready right after lockout", 32'(req_ready), 1);
    exp_cmd(C_NOP, "R12");
    m_open[b] = fp;
  endtask

  task automatic do_mode(input logic [11:0] mv);
    issue(1'b1, 2'd0, 12'd0, 9'd0, mv);
    if (mv[2:0] inside {3'd4, 3'd5, 3'd6}) begin
      exp_idle_nop("R10");
      check(req_ready, "R10", "reserved code consumed without command", 32'(req_ready), 1);
      return;
    end
    if (m_open != 4'd0) precharge_seq("R4");
    exp_cmd(C_MRS, "R3");
    exp_addr(2'd0, mv & 12'hBFF, "R3");
    @(negedge clk);
    for (int i = 0; i < T_MRD; i++) begin
      exp_idle_nop("R5");
      @(negedge clk);
    end
    check(req_ready, "R5", "ready after mode-load gap", 32'(req_ready), 1);
    m_loaded = 1'b1;
    m_bl     = mv[2:0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    summary();
  end

  initial begin
    int unsigned seed;
    checks = 0; errors = 0; finished = 1'b0;
    m_loaded = 1'b0; m_bl = 3'd0; m_open = '0; exp_idx = 0;
    req_valid = 1'b0; req_is_mode = 1'b0; req_bank = '0; req_row = '0;
    req_col = '0; req_mode_val = '0;
    seed = $urandom(32'd20250611);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11: state during reset
    exp_idle_nop("R11");
    check(req_ready, "R11", "ready in reset", 32'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    exp_idle_nop("R11");
    check(req_ready, "R11", "ready after reset", 32'(req_ready), 1);

    do_write(2'd1, 12'h123, 9'h045);      // R6
    do_mode(12'h022);                     // BL 4, R3
    do_mode(12'h025);                     // reserved, R10
    do_write(2'd1, 12'hABC, 9'h1F0);      // still BL 4, R10
    do_mode(12'h423);                     // A10 forced low, BL 8
    do_write(2'd0, 12'h001, 9'h000);
    do_mode(12'h030);                     // BL 1
    do_write(2'd3, 12'hFFF, 9'h1FF);

    for (int it = 0; it < 30; it++) begin
      int r;
      r = int'($urandom % 8);
      if (r == 0) begin
        do_mode(12'((($urandom % 8) << 4) | ($urandom % 4)));
      end else if (r == 1) begin
        do_mode(12'(4 + ($urandom % 3)));
      end else begin
        do_write(2'($urandom), 12'($urandom), 9'($urandom));
      end
    end

    do_mode(12'h027);                     // full page, R8
    do_write(2'd2, 12'h055, 9'h010);
    do_write(2'd3, 12'h066, 9'h000);      // other bank: no precharge
    do_write(2'd2, 12'h077, 9'h100);      // open bank: precharge first
    do_mode(12'h021);                     // open banks: precharge then load, R4
    do_write(2'd2, 12'h088, 9'h002);

    repeat (2) @(negedge clk);
    summary();
  end

endmodule